// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the transfer engine of a four-channel DMA controller. It watches the request flags, mask bits and mode bytes that a separate register block holds. It raises a hold request toward the bus owner. Each rising clock edge with hold acknowledge high, it performs one transfer cycle for the eligible channel with the highest priority. Each cycle advances that channel's current address and current count. The new values are presented on a write-back port, which the register block captures on the same edge.

When the count wraps from zero to all ones, the channel reaches terminal count. The block pulses TC together with that channel's DACK and reports the terminal-count status bit. It then either requests that the channel be masked or writes back the base values for an autoinit reload. After terminal count it drops its hold request until acknowledge has been released. Data movement itself is shown only by three mutually exclusive strobes: device-to-memory, memory-to-device and verify. Each is registered together with the memory address used.

Top module: `dmaseq_core`

## Requirements
- R1: Among channels whose request flag is set and whose mask bit is clear, the lowest-numbered channel is served, and at most one DACK bit is high.
- R2: `hrq_o` is high exactly when some channel is eligible and the block is not yielding. No DACK, strobe or write-back occurs on an edge where `hlda_i` is low.
- R3: Each transfer writes back the current count minus one. It also writes back the current address plus one, or minus one when mode bit 5 is set. The write-back is valid in the same cycle as the granting edge.
- R4: A transfer that starts with a current count of 0 writes back 0xFFFF. It pulses `set_tc_o` for that channel, and `tc_o` is high in the same cycle as the final DACK.
- R5: At terminal count with mode bit 4 clear, `set_mask_o` is pulsed for the channel. With bit 4 set, the base address and base count are written back instead, and the mask is untouched.
- R6: Mode bits 3:2 select the strobe: 1 gives `to_mem_o`, 2 gives `to_dev_o`, 0 gives `verify_o`. `mem_addr_o` carries the address the channel held before the transfer.
- R7: Transfer kind 3 raises `err_type_o` and gives no data strobe, but address and count still advance.
- R8: After a terminal-count transfer, `hrq_o` is low and no further transfer occurs while `hlda_i` stays high. Once `hlda_i` has been low at one edge, requests are honoured again.
- R9: In single mode (mode bits 7:6 = 01), `hrq_o` drops after each transfer and stays low until `hlda_i` has been low at one edge.
- R10: When a channel's `drq_i` falls, `clr_req_o` pulses for that channel in the same cycle. The channel is not counted as eligible in that cycle.
- R11: In cascade mode (bits 7:6 = 11), a granted channel gets DACK only: no strobe, no write-back, no TC.
- R12: In block mode (bits 7:6 = 10), `err_mode_o` is raised and the transfer otherwise proceeds as in demand mode (00).
- R13: After reset, DACK, TC, all strobes, both error flags and the write-back enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hlda_i | input | 1 | Hold acknowledge from the bus owner |
| drq_i | input | NCH (4) | Peripheral request lines |
| req_i | input | NCH | Request status flags from the register block |
| mask_i | input | NCH | Mask bits from the register block |
| mode_i | input | NCH x 8 | Mode byte per channel |
| base_addr_i | input | NCH x AW (16) | Base address per channel |
| base_cnt_i | input | NCH x CW (16) | Base count per channel |
| cur_addr_i | input | NCH x AW | Current address per channel |
| cur_cnt_i | input | NCH x CW | Current count per channel |
| hrq_o | output | 1 | Hold request |
| clr_req_o | output | NCH | Clear request flag (DRQ fell) |
| wb_en_o | output | 1 | Write-back valid |
| wb_ch_o | output | CHW (2) | Write-back channel |
| wb_addr_o | output | AW | New current address |
| wb_cnt_o | output | CW | New current count |
| set_mask_o | output | NCH | Set mask bit request |
| set_tc_o | output | NCH | Set terminal-count status bit |
| dack_o | output | NCH | DMA acknowledge |
| tc_o | output | 1 | Terminal count pulse |
| mem_addr_o | output | AW | Memory address of the transfer |
| to_mem_o | output | 1 | Device-to-memory strobe |
| to_dev_o | output | 1 | Memory-to-device strobe |
| verify_o | output | 1 | Verify strobe |
| err_type_o | output | 1 | Illegal transfer kind flag |
| err_mode_o | output | 1 | Unsupported block mode flag |

## Verification
A wrong priority or a stale eligibility term shows at once as the wrong DACK bit in the cycle after the acknowledged edge. A wrong write-back, such as a bad increment direction, a missed reload or a wrong wrap value, shows in the register model at that same edge. It also shows in the address the next transfer presents. A yield flag that is set or cleared wrongly shows in `hrq_o` within one cycle of the terminal-count or single-mode transfer, and as an extra or missing DACK on the following acknowledged edge.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

    typedef enum logic [1:0] {
        OM_DEMAND  = 2'd0,
        OM_SINGLE  = 2'd1,
        OM_BLOCK   = 2'd2,
        OM_CASCADE = 2'd3
    } op_mode_e;

    typedef enum logic [1:0] {
        XK_VERIFY = 2'd0,
        XK_TO_MEM = 2'd1,
        XK_TO_DEV = 2'd2,
        XK_BAD    = 2'd3
    } xfer_kind_e;

    // Mode byte layout: [7:6] op, [5] decrement, [4] reload, [3:2] kind, [1:0] unused
    typedef struct packed {
        op_mode_e   op;
        logic       dec;
        logic       reload;
        xfer_kind_e kind;
        logic [1:0] spare;
    } mode_t;

    function automatic mode_t unpack_mode(input logic [7:0] raw);
        return mode_t'(raw);
    endfunction

endpackage

// File: rtl/dmaseq_pick.sv
module dmaseq_pick #(
    parameter int NCH = 4,
    localparam int CHW = $clog2(NCH)
) (
    input  logic [NCH-1:0] elig_i,
    output logic [NCH-1:0] grant_o,
    output logic [CHW-1:0] idx_o,
    output logic           valid_o
);
    // Scan from the top down so the lowest index is left standing.
    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (elig_i[i]) begin
                grant_o = '0;
                grant_o[i] = 1'b1;
                idx_o = CHW'(i);
            end
        end
        valid_o = |elig_i;
    end
endmodule

// File: rtl/dmaseq_step.sv
module dmaseq_step
    import dmaseq_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic [AW-1:0] cur_addr_i,
    input  logic [CW-1:0] cur_cnt_i,
    input  logic [AW-1:0] base_addr_i,
    input  logic [CW-1:0] base_cnt_i,
    input  mode_t         mode_i,
    output logic [AW-1:0] nxt_addr_o,
    output logic [CW-1:0] nxt_cnt_o,
    output logic          expire_o
);
    logic [AW-1:0] moved_addr;
    logic [CW-1:0] less_cnt;

    always_comb begin
        moved_addr = mode_i.dec ? cur_addr_i - AW'(1) : cur_addr_i + AW'(1);
        less_cnt   = cur_cnt_i - CW'(1);
        expire_o   = (cur_cnt_i == '0);
        if (expire_o && mode_i.reload) begin
            nxt_addr_o = base_addr_i;
            nxt_cnt_o  = base_cnt_i;
        end else begin
            nxt_addr_o = moved_addr;
            nxt_cnt_o  = less_cnt;
        end
    end
endmodule

// File: rtl/dmaseq_hold.sv
module dmaseq_hold #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           hlda_i,
    input  logic [NCH-1:0] drq_i,
    input  logic           any_elig_i,
    input  logic           yield_set_i,
    output logic [NCH-1:0] drq_fell_o,
    output logic           yield_o,
    output logic           hrq_o
);
    logic [NCH-1:0] drq_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            drq_prev <= '0;
            yield_o  <= 1'b0;
        end else begin
            drq_prev <= drq_i;
            if (!hlda_i)
                yield_o <= 1'b0;
            else if (yield_set_i)
                yield_o <= 1'b1;
        end
    end

    assign drq_fell_o = drq_prev & ~drq_i;
    assign hrq_o      = any_elig_i & ~yield_o;

    // R9
    yield_release_chk: assert property (@(posedge clk) disable iff (rst)
        (yield_o && !hlda_i) |=> !yield_o);
endmodule

// File: rtl/dmaseq_core.sv
module dmaseq_core
    import dmaseq_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 16,
    localparam int CHW = $clog2(NCH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    hlda_i,
    input  logic [NCH-1:0]          drq_i,
    input  logic [NCH-1:0]          req_i,
    input  logic [NCH-1:0]          mask_i,
    input  logic [NCH-1:0][7:0]     mode_i,
    input  logic [NCH-1:0][AW-1:0]  base_addr_i,
    input  logic [NCH-1:0][CW-1:0]  base_cnt_i,
    input  logic [NCH-1:0][AW-1:0]  cur_addr_i,
    input  logic [NCH-1:0][CW-1:0]  cur_cnt_i,
    output logic                    hrq_o,
    output logic [NCH-1:0]          clr_req_o,
    output logic                    wb_en_o,
    output logic [CHW-1:0]          wb_ch_o,
    output logic [AW-1:0]           wb_addr_o,
    output logic [CW-1:0]           wb_cnt_o,
    output logic [NCH-1:0]          set_mask_o,
    output logic [NCH-1:0]          set_tc_o,
    output logic [NCH-1:0]          dack_o,
    output logic                    tc_o,
    output logic [AW-1:0]           mem_addr_o,
    output logic                    to_mem_o,
    output logic                    to_dev_o,
    output logic                    verify_o,
    output logic                    err_type_o,
    output logic                    err_mode_o
);
    logic [NCH-1:0] elig, grant, drq_fell;
    logic [CHW-1:0] idx;
    logic           valid, yield, yield_set, go, adv, expire;
    mode_t          sel_mode;
    logic [AW-1:0]  nxt_addr;
    logic [CW-1:0]  nxt_cnt;

    dmaseq_hold #(.NCH(NCH)) u_hold (
        .clk         (clk),
        .rst         (rst),
        .hlda_i      (hlda_i),
        .drq_i       (drq_i),
        .any_elig_i  (valid),
        .yield_set_i (yield_set),
        .drq_fell_o  (drq_fell),
        .yield_o     (yield),
        .hrq_o       (hrq_o)
    );

    assign elig = req_i & ~mask_i & ~drq_fell;

    dmaseq_pick #(.NCH(NCH)) u_pick (
        .elig_i  (elig),
        .grant_o (grant),
        .idx_o   (idx),
        .valid_o (valid)
    );

    assign sel_mode = unpack_mode(mode_i[idx]);

    dmaseq_step #(.AW(AW), .CW(CW)) u_step (
        .cur_addr_i  (cur_addr_i[idx]),
        .cur_cnt_i   (cur_cnt_i[idx]),
        .base_addr_i (base_addr_i[idx]),
        .base_cnt_i  (base_cnt_i[idx]),
        .mode_i      (sel_mode),
        .nxt_addr_o  (nxt_addr),
        .nxt_cnt_o   (nxt_cnt),
        .expire_o    (expire)
    );

    always_comb begin
        go         = hlda_i & ~yield & valid;
        adv        = go & (sel_mode.op != OM_CASCADE);
        yield_set  = adv & (expire | (sel_mode.op == OM_SINGLE));
        wb_en_o    = adv;
        wb_ch_o    = idx;
        wb_addr_o  = nxt_addr;
        wb_cnt_o   = nxt_cnt;
        set_tc_o   = (adv && expire) ? grant : '0;
        set_mask_o = (adv && expire && !sel_mode.reload) ? grant : '0;
        clr_req_o  = drq_fell;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dack_o     <= '0;
            tc_o       <= 1'b0;
            mem_addr_o <= '0;
            to_mem_o   <= 1'b0;
            to_dev_o   <= 1'b0;
            verify_o   <= 1'b0;
            err_type_o <= 1'b0;
            err_mode_o <= 1'b0;
        end else begin
            dack_o     <= go ? grant : '0;
            tc_o       <= adv & expire;
            if (adv)
                mem_addr_o <= cur_addr_i[idx];
            to_mem_o   <= adv & (sel_mode.kind == XK_TO_MEM);
            to_dev_o   <= adv & (sel_mode.kind == XK_TO_DEV);
            verify_o   <= adv & (sel_mode.kind == XK_VERIFY);
            err_type_o <= adv & (sel_mode.kind == XK_BAD);
            err_mode_o <= go & (sel_mode.op == OM_BLOCK);
        end
    end

    // R1
    single_dack_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack_o));
    // R2
    dack_needs_hlda_chk: assert property (@(posedge clk) disable iff (rst)
        (dack_o != '0) |-> $past(hlda_i));
    // R4
    tc_with_dack_chk: assert property (@(posedge clk) disable iff (rst)
        tc_o |-> (dack_o != '0));
    // R6
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({to_mem_o, to_dev_o, verify_o}));
    // R7
    bad_kind_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        err_type_o |-> !(to_mem_o || to_dev_o || verify_o));
    // R8
    tc_drops_hrq_chk: assert property (@(posedge clk) disable iff (rst)
        tc_o |-> !hrq_o);
endmodule

// File: tb/dmaseq_core_test.sv
`timescale 1ns/1ps
module dmaseq_core_test;
    localparam int NCH = 4;
    localparam int AW  = 16;
    localparam int CW  = 16;

    logic clk = 0;
    logic rst = 1;
    logic hlda = 0;
    logic [NCH-1:0] drq = '0;
    logic [NCH-1:0] req_m = '0;
    logic [NCH-1:0] mask_m = '1;
    logic [NCH-1:0] tcst = '0;
    logic [NCH-1:0][7:0] mode_m = '0;
    logic [NCH-1:0][AW-1:0] badr_m = '0, cadr_m = '0;
    logic [NCH-1:0][CW-1:0] bcnt_m = '0, ccnt_m = '0;

    logic hrq, wb_en, tc, to_mem, to_dev, verify, err_type, err_mode;
    logic [NCH-1:0] clr_req, set_mask, set_tc, dack;
    logic [1:0] wb_ch;
    logic [AW-1:0] wb_addr, mem_addr;
    logic [CW-1:0] wb_cnt;

    int total = 0, failed = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dmaseq_core #(.NCH(NCH), .AW(AW), .CW(CW)) uut (
        .clk(clk), .rst(rst), .hlda_i(hlda), .drq_i(drq), .req_i(req_m),
        .mask_i(mask_m), .mode_i(mode_m), .base_addr_i(badr_m),
        .base_cnt_i(bcnt_m), .cur_addr_i(cadr_m), .cur_cnt_i(ccnt_m),
        .hrq_o(hrq), .clr_req_o(clr_req), .wb_en_o(wb_en), .wb_ch_o(wb_ch),
        .wb_addr_o(wb_addr), .wb_cnt_o(wb_cnt), .set_mask_o(set_mask),
        .set_tc_o(set_tc), .dack_o(dack), .tc_o(tc), .mem_addr_o(mem_addr),
        .to_mem_o(to_mem), .to_dev_o(to_dev), .verify_o(verify),
        .err_type_o(err_type), .err_mode_o(err_mode)
    );

    // Register-block model
    always @(posedge clk) begin
        if (wb_en) begin
            cadr_m[wb_ch] <= wb_addr;
            ccnt_m[wb_ch] <= wb_cnt;
        end
        mask_m <= mask_m | set_mask;
        tcst   <= tcst | set_tc;
        req_m  <= req_m & ~clr_req;
    end

    function automatic logic [7:0] md(input logic [1:0] op, input logic dec,
                                      input logic rl, input logic [1:0] kind);
        return {op, dec, rl, kind, 2'b00};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clean();
        hlda = 0; drq = '0; req_m = '0; mask_m = '1; tcst = '0;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic cfg(input int ch, input logic [7:0] m, input logic [15:0] a,
                       input logic [15:0] c, input logic [15:0] ba, input logic [15:0] bc);
        mode_m[ch] = m; cadr_m[ch] = a; ccnt_m[ch] = c;
        badr_m[ch] = ba; bcnt_m[ch] = bc;
        req_m[ch] = 1'b1; mask_m[ch] = 1'b0;
    endtask

    task automatic ack_edge();
        hlda = 1; @(posedge clk); @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R13 dack", dack, 0);
        chk("R13 tc", tc, 0);
        chk("R13 strobes", {to_mem, to_dev, verify, err_type, err_mode}, 0);
        chk("R13 wb_en", wb_en, 0);
        chk("R13 hrq", hrq, 0);
    endtask

    task automatic t_priority();
        cfg(1, md(0,0,0,1), 16'h0100, 5, 0, 5);
        cfg(2, md(0,0,0,1), 16'h0200, 5, 0, 5);
        cfg(3, md(0,0,0,1), 16'h0300, 5, 0, 5);
        #1 chk("R2 hrq raised", hrq, 1);
        ack_edge();
        chk("R1 lowest wins", dack, 4'b0010);
        chk("R1 mem addr", mem_addr, 16'h0100);
        mask_m[1] = 1;
        @(posedge clk); @(negedge clk);
        chk("R1 next channel", dack, 4'b0100);
        clean();
    endtask

    task automatic t_step();
        cfg(0, md(0,0,0,1), 16'h1000, 3, 0, 3);
        ack_edge();
        chk("R3 inc addr", cadr_m[0], 16'h1001);
        chk("R3 count", ccnt_m[0], 2);
        chk("R6 to_mem", {to_mem, to_dev, verify}, 3'b100);
        chk("R6 pre addr", mem_addr, 16'h1000);
        mode_m[0] = md(0,1,0,1); cadr_m[0] = 16'h2000;
        @(posedge clk); @(negedge clk);
        chk("R3 dec addr", cadr_m[0], 16'h1FFF);
        chk("R3 count2", ccnt_m[0], 1);
        hlda = 0; @(posedge clk); @(negedge clk);
        chk("R2 no ack no dack", dack, 0);
        chk("R2 no ack no change", cadr_m[0], 16'h1FFF);
        clean();
    endtask

    task automatic t_tc_mask();
        cfg(2, md(0,0,0,2), 16'h0040, 0, 16'h0010, 9);
        ack_edge();
        chk("R4 tc", tc, 1);
        chk("R4 dack", dack, 4'b0100);
        chk("R4 wrap", ccnt_m[2], 16'hFFFF);
        chk("R4 status", tcst, 4'b0100);
        chk("R5 masked", mask_m[2], 1);
        chk("R5 addr adv", cadr_m[2], 16'h0041);
        chk("R8 hrq low", hrq, 0);
        clean();
    endtask

    task automatic t_tc_reload();
        cfg(3, md(0,0,1,1), 16'h03AB, 0, 16'h0300, 7);
        ack_edge();
        chk("R4 tc reload", tc, 1);
        chk("R5 addr reload", cadr_m[3], 16'h0300);
        chk("R5 cnt reload", ccnt_m[3], 7);
        chk("R5 mask kept", mask_m[3], 0);
        @(posedge clk); @(negedge clk);
        chk("R8 no second xfer", dack, 0);
        chk("R8 addr held", cadr_m[3], 16'h0300);
        hlda = 0; @(posedge clk); @(negedge clk);
        chk("R8 hrq back", hrq, 1);
        clean();
    endtask

    task automatic t_single();
        cfg(1, md(1,0,0,1), 16'h0500, 10, 0, 10);
        ack_edge();
        chk("R9 first dack", dack, 4'b0010);
        chk("R9 hrq drops", hrq, 0);
        @(posedge clk); @(negedge clk);
        chk("R9 no second", dack, 0);
        chk("R9 one advance", cadr_m[1], 16'h0501);
        hlda = 0; @(posedge clk); @(negedge clk);
        chk("R9 hrq back", hrq, 1);
        clean();
    endtask

    task automatic t_demand_burst();
        cfg(0, md(0,0,0,1), 16'h0700, 10, 0, 10);
        ack_edge();
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        chk("R2 burst addr", cadr_m[0], 16'h0703);
        chk("R2 hrq held", hrq, 1);
        clean();
    endtask

    task automatic t_kinds();
        cfg(0, md(0,0,0,2), 16'h0800, 10, 0, 10);
        ack_edge();
        chk("R6 to_dev", {to_mem, to_dev, verify}, 3'b010);
        mode_m[0] = md(0,0,0,0);
        @(posedge clk); @(negedge clk);
        chk("R6 verify", {to_mem, to_dev, verify}, 3'b001);
        mode_m[0] = md(0,0,0,3);
        @(posedge clk); @(negedge clk);
        chk("R7 err", err_type, 1);
        chk("R7 no strobe", {to_mem, to_dev, verify}, 0);
        chk("R7 adv", cadr_m[0], 16'h0803);
        chk("R7 cnt", ccnt_m[0], 7);
        clean();
    endtask

    task automatic t_drq_fall();
        cfg(0, md(0,0,0,1), 16'h0900, 10, 0, 10);
        drq[0] = 1; @(posedge clk); @(negedge clk);
        drq[0] = 0; #1;
        chk("R10 clr pulse", clr_req, 4'b0001);
        chk("R10 hrq low", hrq, 0);
        @(posedge clk); @(negedge clk);
        chk("R10 flag cleared", req_m[0], 0);
        chk("R10 pulse ends", clr_req, 0);
        clean();
    endtask

    task automatic t_cascade();
        cfg(0, md(3,0,0,1), 16'h0A00, 10, 0, 10);
        ack_edge();
        chk("R11 dack", dack, 4'b0001);
        chk("R11 no strobe", {to_mem, to_dev, verify, tc}, 0);
        chk("R11 addr kept", cadr_m[0], 16'h0A00);
        clean();
    endtask

    task automatic t_block();
        cfg(1, md(2,0,0,1), 16'h0B00, 10, 0, 10);
        ack_edge();
        chk("R12 flag", err_mode, 1);
        chk("R12 adv", cadr_m[1], 16'h0B01);
        chk("R12 strobe", to_mem, 1);
        clean();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        @(posedge clk); @(negedge clk);
        t_reset();
        t_priority();
        t_step();
        t_tc_mask();
        t_tc_reload();
        t_single();
        t_demand_burst();
        t_kinds();
        t_drq_fall();
        t_cascade();
        t_block();
        done = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; failed++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end
endmodule